// File: doc/BRIEF.md
# Slave Serial Audio Port with Selectable Bit Clock Polarity

This block is the slave side of a two-wire-per-direction stereo audio link. An external controller drives a bit clock and two frame clocks: one frames the incoming playback stream, the other frames the outgoing capture stream. The block turns the incoming stream into parallel 24-bit left and right words for the playback converter. It also serialises parallel capture words onto the outgoing data pin.

Every serial input is oversampled in the system clock domain through synchronisers. A runtime polarity input decides which bit clock edge samples data and frame clocks, and which edge launches outgoing data. The framing is I2S style. Each word is sent MSB first, starting one bit clock after the frame clock changes level. A low frame clock marks the left channel.

Top module: `sap_port`

## Requirements
- R1: After reset, `sdata_o`, `dac_valid_o`, `dac_left_o` and `dac_right_o` are all zero.
- R2: With `bclk_inv_i` = 0, `sdata_i`, `dac_fclk_i` and `adc_fclk_i` are sampled on the rising edge of `bclk_i`.
- R3: With `bclk_inv_i` = 0, `sdata_o` changes only after a falling edge of `bclk_i`, so it is stable at every rising edge.
- R4: With `bclk_inv_i` = 1, sampling moves to the falling edge and `sdata_o` changes only after a rising edge.
- R5: A word's MSB is the bit sampled on the second sampling edge after the frame clock changes level. Its LSB is sampled on the first sampling edge after the next change. Frame clock 0 is left and 1 is right.
- R6: Received words are 24 bits. Bits past the 24th in a slot are ignored.
- R7: A slot shorter than 24 bits yields the received bits left-justified, with the missing low bits zero.
- R8: `dac_valid_o` pulses for exactly one system clock cycle per completed left/right pair. No pulse follows a right word that was not preceded by a full left word since synchronisation.
- R9: The capture stream is framed by `adc_fclk_i`. The word for that channel is captured at the sampling edge that sees the level change. It is sent MSB first, so its MSB is present at the next sampling edge, and `sdata_o` is 0 after its 24th bit.
- R10: `master_sel_i` has no effect. `sdata_i` is always an input and `sdata_o` is always an output.
- R11: `dac_left_o` and `dac_right_o` change only in the cycle where `dac_valid_o` is high, and hold between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | External bit clock |
| dac_fclk_i | input | 1 | Frame clock of the received stream (0 = left) |
| adc_fclk_i | input | 1 | Frame clock of the transmitted stream (0 = left) |
| sdata_i | input | 1 | Serial playback data in |
| bclk_inv_i | input | 1 | 0: sample on rising, launch on falling; 1: swapped |
| master_sel_i | input | 1 | Master/slave select; only slave operation is built |
| adc_left_i | input | WORD_W | Left capture word to transmit |
| adc_right_i | input | WORD_W | Right capture word to transmit |
| sdata_o | output | 1 | Serial capture data out |
| dac_left_o | output | WORD_W | Last received left word |
| dac_right_o | output | WORD_W | Last received right word |
| dac_valid_o | output | 1 | One-cycle pulse when a left/right pair is delivered |

## Verification
The bench feeds slots of 16, 20, 24 and 32 bits so that truncation and zero fill are exercised. A design that shifted a short word would misplace the MSB, and one that counted bits past the 24th would corrupt the LSBs. Inputs change on the launch edge and the output is read on the sampling edge, under both polarities. A design that ignored the polarity input, or swapped only one of the two edges, would shift every word by one bit or read data as it changes. The first pair after synchronisation starts in mid-right-slot, and the bench checks that no strobe appears there. After the last pair it checks that the outputs hold and no stray strobe follows.

// File: rtl/sap_pkg.sv
package sap_pkg;
  localparam int unsigned WORD_W = 24;

  typedef struct packed {
    logic bclk;
    logic dac_fclk;
    logic adc_fclk;
    logic sdata;
  } serial_in_t;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/sap_sync.sv
module sap_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '0;
    else         stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sap_edge.sv
module sap_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic inv_i,
  output logic sample_o,
  output logic launch_o
);
  logic bclk_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_q <= 1'b0;
    else         bclk_q <= bclk_i;
  end

  assign rise = bclk_i & ~bclk_q;
  assign fall = ~bclk_i & bclk_q;

  assign sample_o = inv_i ? fall : rise;
  assign launch_o = inv_i ? rise : fall;
endmodule

// File: rtl/sap_rx.sv
module sap_rx #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              sd_i,
  input  logic              fclk_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  localparam logic [WORD_W-1:0] MSB_POS = {1'b1, {(WORD_W-1){1'b0}}};

  logic              fclk_q, synced, left_ok;
  logic [WORD_W-1:0] shreg, pos, left_stage, word_nxt;
  logic              slot_end;

  // one-hot bit position; runs out after WORD_W bits so extra bits drop
  assign word_nxt = sd_i ? (shreg | pos) : shreg;
  assign slot_end = fclk_i ^ fclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fclk_q     <= 1'b0;
      synced     <= 1'b0;
      left_ok    <= 1'b0;
      shreg      <= '0;
      pos        <= '0;
      left_stage <= '0;
      left_o     <= '0;
      right_o    <= '0;
      valid_o    <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (sample_i) begin
        fclk_q <= fclk_i;
        if (slot_end) begin
          synced <= 1'b1;
          shreg  <= '0;
          pos    <= MSB_POS;
          if (synced) begin
            if (fclk_q == sap_pkg::CH_LEFT) begin
              left_stage <= word_nxt;
              left_ok    <= 1'b1;
            end else begin
              left_ok <= 1'b0;
              if (left_ok) begin
                left_o  <= left_stage;
                right_o <= word_nxt;
                valid_o <= 1'b1;
              end
            end
          end
        end else begin
          shreg <= word_nxt;
          pos   <= pos >> 1;
        end
      end
    end
  end
endmodule

// File: rtl/sap_tx.sv
module sap_tx #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              launch_i,
  input  logic              fclk_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  output logic              sd_o
);
  localparam logic [WORD_W-1:0] MSB_POS = {1'b1, {(WORD_W-1){1'b0}}};

  logic              fclk_q;
  logic [WORD_W-1:0] word, pos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fclk_q <= 1'b0;
      word   <= '0;
      pos    <= '0;
      sd_o   <= 1'b0;
    end else begin
      if (sample_i) begin
        fclk_q <= fclk_i;
        if (fclk_i ^ fclk_q) begin
          word <= (fclk_i == sap_pkg::CH_RIGHT) ? right_i : left_i;
          pos  <= MSB_POS;
        end
      end
      if (launch_i) begin
        sd_o <= |(word & pos);
        pos  <= pos >> 1;
      end
    end
  end
endmodule

// File: rtl/sap_port.sv
module sap_port #(
  parameter int unsigned WORD_W      = sap_pkg::WORD_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              dac_fclk_i,
  input  logic              adc_fclk_i,
  input  logic              sdata_i,
  input  logic              bclk_inv_i,
  input  logic              master_sel_i,
  input  logic [WORD_W-1:0] adc_left_i,
  input  logic [WORD_W-1:0] adc_right_i,
  output logic              sdata_o,
  output logic [WORD_W-1:0] dac_left_o,
  output logic [WORD_W-1:0] dac_right_o,
  output logic              dac_valid_o
);
  localparam int unsigned IN_W = $bits(sap_pkg::serial_in_t);

  sap_pkg::serial_in_t raw_in, syn_in;
  logic                sample_stb, launch_stb;

  assign raw_in = '{bclk: bclk_i, dac_fclk: dac_fclk_i,
                    adc_fclk: adc_fclk_i, sdata: sdata_i};

  sap_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  sap_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bclk_i  (syn_in.bclk),
    .inv_i   (bclk_inv_i),
    .sample_o(sample_stb),
    .launch_o(launch_stb)
  );

  sap_rx #(.WORD_W(WORD_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sample_stb),
    .sd_i    (syn_in.sdata),
    .fclk_i  (syn_in.dac_fclk),
    .left_o  (dac_left_o),
    .right_o (dac_right_o),
    .valid_o (dac_valid_o)
  );

  sap_tx #(.WORD_W(WORD_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sample_stb),
    .launch_i(launch_stb),
    .fclk_i  (syn_in.adc_fclk),
    .left_i  (adc_left_i),
    .right_i (adc_right_i),
    .sd_o    (sdata_o)
  );
endmodule

// File: rtl/sap_port_chk.sv
module sap_port_chk #(
  parameter int unsigned WORD_W = sap_pkg::WORD_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              master_sel_i,
  input logic              sample_stb,
  input logic              launch_stb,
  input logic              sdata_o,
  input logic              dac_valid_o,
  input logic [WORD_W-1:0] dac_left_o,
  input logic [WORD_W-1:0] dac_right_o
);
  assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_valid_o |=> !dac_valid_o);

  // R3/R4: output moves only after the launch strobe
  assert_launch_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> $past(launch_stb));

  assert_launch_not_sample_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> !$past(sample_stb));

  assert_hold_left_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dac_left_o) |-> dac_valid_o);

  assert_hold_right_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dac_right_o) |-> dac_valid_o);

  assert_mode_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(master_sel_i) |-> ($stable(sdata_o) || $past(launch_stb)));
endmodule

bind sap_port sap_port_chk #(.WORD_W(WORD_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .master_sel_i(master_sel_i),
  .sample_stb  (sample_stb),
  .launch_stb  (launch_stb),
  .sdata_o     (sdata_o),
  .dac_valid_o (dac_valid_o),
  .dac_left_o  (dac_left_o),
  .dac_right_o (dac_right_o)
);

// File: tb/sap_port_tb_top.sv
module sap_port_tb_top;
  localparam int W = 24;
  localparam int H = 6;  // system clocks per bit clock half period

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bclk = 1'b0, dac_fclk = 1'b1, adc_fclk = 1'b1, sdata_in = 1'b0;
  logic         pol = 1'b0, msel = 1'b0;
  logic [W-1:0] adc_l = '0, adc_r = '0;
  logic         sdata_out, valid;
  logic [W-1:0] dac_l, dac_r;

  int errors = 0, checks = 0, vcnt = 0;
  logic [W-1:0] cap_l, cap_r, exp_l, exp_r;
  bit exp_pending = 0;
  logic carry = 1'b0;

  always #5 clk = ~clk;

  sap_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .dac_fclk_i(dac_fclk),
    .adc_fclk_i(adc_fclk), .sdata_i(sdata_in), .bclk_inv_i(pol),
    .master_sel_i(msel), .adc_left_i(adc_l), .adc_right_i(adc_r),
    .sdata_o(sdata_out), .dac_left_o(dac_l), .dac_right_o(dac_r),
    .dac_valid_o(valid)
  );

  always @(negedge clk) if (rst_n && valid) begin
    vcnt++;
    cap_l = dac_l;
    cap_r = dac_r;
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rx_mask(input logic [W-1:0] w, input int n);
    if (n >= W) return w;
    return w & ~((W'(1) << (W - n)) - W'(1));
  endfunction

  function automatic logic bit_of(input logic [W-1:0] w, input int idx);
    if (idx < W) return w[W-1-idx];
    return logic'($urandom & 1);
  endfunction

  task automatic bit_cycle(input logic ch, input logic d, output logic so);
    logic launch_lvl;
    launch_lvl = pol;  // pol 0: launch on fall (go low); pol 1: launch on rise
    @(negedge clk);
    bclk = launch_lvl; dac_fclk = ch; adc_fclk = ch; sdata_in = d;
    repeat (H) @(negedge clk);
    so = sdata_out;
    bclk = ~launch_lvl;
    repeat (H-1) @(negedge clk);
  endtask

  task automatic check_pair(input int base);
    if (exp_pending) begin
      check("R8 one strobe per pair", W'(vcnt - base), W'(1));
      check("R5/R6/R7 left word", cap_l, exp_l);
      check("R5/R6/R7 right word", cap_r, exp_r);
    end else begin
      check("R8 no strobe without full pair", W'(vcnt - base), W'(0));
    end
    exp_pending = 0;
  endtask

  task automatic slot(input logic ch, input logic [W-1:0] w, input logic [W-1:0] aw,
                      input int n, input bit chk_tx, input string req);
    for (int k = 0; k < n; k++) begin
      logic d, so;
      int base;
      base = vcnt;
      d = (k == 0) ? carry : bit_of(w, k-1);
      bit_cycle(ch, d, so);
      if (chk_tx && k >= 1)
        check(req, W'(so), W'((k-1 < W) ? aw[W-k] : 1'b0));
      if (k == 0 && ch == 1'b0) check_pair(base);
    end
    carry = bit_of(w, n-1);
  endtask

  task automatic frame(input logic [W-1:0] l, input logic [W-1:0] r, input int n, input string req);
    logic [W-1:0] al, ar;
    al = W'($urandom); ar = W'($urandom);
    @(negedge clk);
    adc_l = al; adc_r = ar;
    slot(1'b0, l, al, n, 1'b1, req);
    slot(1'b1, r, ar, n, 1'b1, req);
    exp_l = rx_mask(l, n);
    exp_r = rx_mask(r, n);
    exp_pending = 1;
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    check("R1 sdata_o reset", W'(sdata_out), '0);
    check("R1 valid reset", W'(valid), '0);
    check("R1 left reset", dac_l, '0);
    check("R1 right reset", dac_r, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    slot(1'b1, '0, '0, 8, 1'b0, "sync");
    // R2 R3 R5 R9: rising-edge sampling, 24-bit slots
    for (int i = 0; i < 4; i++) frame(W'($urandom), W'($urandom), 24, "R2/R3/R9 tx pol0");
    frame(24'h800001, 24'h7ffffe, 24, "R5 tx directed");
    // R6: long slots, extra bits ignored; tx zero after 24 bits (R9)
    for (int i = 0; i < 3; i++) frame(W'($urandom), W'($urandom), 32, "R6/R9 tx long slot");
    // R7: short slots zero-filled
    for (int i = 0; i < 3; i++) frame(W'($urandom), W'($urandom), 16, "R7 tx short slot");
    // R4: swapped polarity
    pol = 1'b1;
    for (int i = 0; i < 4; i++) frame(W'($urandom), W'($urandom), 24, "R4 tx pol1");
    // R10: master select has no effect
    msel = 1'b1;
    for (int i = 0; i < 3; i++) frame(W'($urandom), W'($urandom), 20, "R10 tx msel");
    frame(24'hffffff, 24'h000000, 25, "R10 tx directed");
    msel = 1'b0;
    pol = 1'b0;
    frame(W'($urandom), W'($urandom), 24, "R4 tx back to pol0");
    // flush last pair, then R11 hold
    slot(1'b0, '0, '0, 6, 1'b0, "flush");
    begin
      int base;
      base = vcnt;
      repeat (60) @(negedge clk);
      check("R11 no stray strobe", W'(vcnt - base), '0);
      check("R11 left held", dac_l, exp_l);
      check("R11 right held", dac_r, exp_r);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule